// File: doc/BRIEF.md
# USB Transmit Endpoint Control and Status

This block holds the control and status logic for one transmit endpoint of a USB device. Software loads a packet into the endpoint buffer and then writes an 8-bit control byte to commit it. The serial side reports three kinds of event: a packet went out and was acknowledged, an attempt went unanswered, or nothing happened. From these the block tracks how many packets the buffer holds (one, or two when double buffering is on), the ready flag seen by software, the retry error, the data toggle and a single interrupt pulse.

Software reads the same byte back at any time. The read has no side effects. The serial data path, the CRC and the buffer storage belong to neighbouring blocks. This block only counts packets.

Top module: `usb_tx_ep_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, and `data_toggle` and `irq` are low.
- R2: The read byte shows the ready flag in bit 0, FIFO-not-empty in bit 1 (high while one or more packets are held) and the error flag in bit 2. Bits 7..3 always read 0. Writes to bit 1 have no effect.
- R3: With `dbl_buf` low, a write with bit 0 set and bit 3 clear commits a packet when the buffer is empty and sets the ready flag. The same commit is ignored while one packet is already held.
- R4: With `dbl_buf` high, the first commit leaves the ready flag at 0 with FIFO-not-empty at 1. The second commit sets the ready flag. A third commit while two packets are held is ignored.
- R5: `phy_sent` while one or more packets are held removes one packet, clears the ready flag, inverts `data_toggle` and raises the interrupt. `phy_sent` with an empty buffer has no effect.
- R6: A write with bit 3 set and bit 0 clear removes one packet, clears the ready flag, clears the retry count and raises the interrupt. On an empty buffer the count stays at zero.
- R7: A write with bits 3 and 0 both set cancels the commit. The packet count is unchanged, the ready flag is cleared and the interrupt is raised.
- R8: When `iso_mode` is low, `phy_nohs` with one or more packets held counts a failed attempt. The third consecutive failure sets the error flag, empties the buffer, clears the ready flag and raises the interrupt. The count restarts after a sent packet, a flush or an error.
- R9: While `iso_mode` is high, `phy_nohs` has no effect.
- R10: Any write with bit 2 clear clears the error flag. A write with bit 2 set leaves the flag unchanged.
- R11: A write with bit 6 set forces `data_toggle` to 0, even when a sent packet would invert it in the same cycle.
- R12: `irq` is high for exactly the one cycle after a cycle that contains a cause (a sent packet, a flush write or a retry error). At all other times it is low.
- R13: When an event and a write arrive in the same cycle, the event is applied first and the write then acts on the result. `phy_sent` takes precedence over `phy_nohs`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_buf | input | 1 | Double buffering enable (two packets) |
| iso_mode | input | 1 | Isochronous endpoint: no retry counting |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control/status byte readback |
| phy_sent | input | 1 | Packet transmitted and acknowledged |
| phy_nohs | input | 1 | Transmission attempt got no handshake |
| data_toggle | output | 1 | Current endpoint data toggle |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench goes after several corner cases:
- A flush on an empty buffer. A design that underflows would show FIFO-not-empty set forever.
- A commit into a full buffer. A design that accepted it would need an extra sent event before it emptied.
- Flush written together with ready. A design that got this wrong would lose or gain a packet.
- The third failed attempt, against a sent packet that resets the count after two failures. A design with an off-by-one error would raise the error too early or too late.
- Same-cycle collisions, such as a toggle clear against a sent packet, or an error clear against a new error. A design with the wrong ordering would leave a stale toggle or a stale error flag.

Long random runs in both buffering modes and both retry modes mix all of these.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;
    // Bit positions in the control byte. Software decodes these.
    localparam int unsigned RDY_BIT = 0;
    localparam int unsigned FNE_BIT = 1;
    localparam int unsigned ERR_BIT = 2;
    localparam int unsigned FLS_BIT = 3;
    localparam int unsigned TGC_BIT = 6;

    typedef struct packed {
        logic rdy;
        logic err;
        logic irq;
    } txep_flags_t;
endpackage

// File: rtl/txep_occupancy.sv
module txep_occupancy #(
    parameter int unsigned DEPTH = 2,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl,
    input  logic          pop,
    input  logic          clear_all,
    input  logic          push,
    input  logic          drop_one,
    output logic [CW-1:0] cnt_d,
    output logic [CW-1:0] cnt_q
);
    logic [CW-1:0] cap;
    logic [CW-1:0] mid;

    always_comb begin
        cap = dbl ? CW'(DEPTH) : CW'(1);
        // Serial events are applied first.
        if (clear_all)
            mid = '0;
        else if (pop && cnt_q != '0)
            mid = cnt_q - CW'(1);
        else
            mid = cnt_q;
        // The register write then acts on that result.
        if (drop_one)
            cnt_d = (mid != '0) ? mid - CW'(1) : '0;
        else if (push && mid < cap)
            cnt_d = mid + CW'(1);
        else
            cnt_d = mid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R6
    flush_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && drop_one && !push) |=> cnt_q == '0);

    // R5
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && cnt_q != '0 && !clear_all && !push && !drop_one)
        |=> cnt_q == $past(cnt_q) - CW'(1));
endmodule

// File: rtl/txep_retry.sv
module txep_retry #(
    parameter int unsigned LIMIT = 3,
    localparam int unsigned RW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail,
    input  logic clr,
    output logic give_up
);
    logic [RW-1:0] tries_d, tries_q;

    always_comb begin
        give_up = fail && (tries_q == RW'(LIMIT - 1));
        if (clr || give_up)
            tries_d = '0;
        else if (fail)
            tries_d = tries_q + RW'(1);
        else
            tries_d = tries_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tries_q <= '0;
        else        tries_q <= tries_d;
    end

    // R8
    retry_climb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clr && !give_up) |=> tries_q == $past(tries_q) + RW'(1));

    // R8
    retry_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || give_up) |=> tries_q == '0);
endmodule

// File: rtl/txep_toggle.sv
module txep_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    input  logic clr,
    output logic tgl_q
);
    logic tgl_d;

    always_comb begin
        tgl_d = tgl_q;
        if (flip) tgl_d = ~tgl_q;
        if (clr)  tgl_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgl_q <= 1'b0;
        else        tgl_q <= tgl_d;
    end

    // R11
    toggle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tgl_q);

    // R5
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flip && !clr) |=> tgl_q != $past(tgl_q));
endmodule

// File: rtl/usb_tx_ep_ctrl.sv
module usb_tx_ep_ctrl #(
    parameter int unsigned DEPTH = 2,
    parameter int unsigned RETRY_LIMIT = 3,
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dbl_buf,
    input  logic       iso_mode,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       phy_sent,
    input  logic       phy_nohs,
    output logic       data_toggle,
    output logic       irq
);
    import usb_txep_pkg::*;

    txep_flags_t   fl_d, fl_q;
    logic [CW-1:0] cnt_d, cnt_q, cap;
    logic          has_pkt, sent_ev, fail_ev, give_up;
    logic          flush_wr, commit_wr, abort_wr, err_clr_wr, tgl_clr_wr;

    always_comb begin
        cap        = dbl_buf ? CW'(DEPTH) : CW'(1);
        has_pkt    = (cnt_q != '0);
        sent_ev    = phy_sent && has_pkt;
        fail_ev    = phy_nohs && !phy_sent && has_pkt && !iso_mode;
        flush_wr   = reg_wr && reg_wdata[FLS_BIT];
        commit_wr  = reg_wr && reg_wdata[RDY_BIT] && !reg_wdata[FLS_BIT];
        abort_wr   = reg_wr && reg_wdata[RDY_BIT] && reg_wdata[FLS_BIT];
        err_clr_wr = reg_wr && !reg_wdata[ERR_BIT];
        tgl_clr_wr = reg_wr && reg_wdata[TGC_BIT];
    end

    txep_occupancy #(.DEPTH(DEPTH)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbl       (dbl_buf),
        .pop       (sent_ev),
        .clear_all (give_up),
        .push      (commit_wr),
        .drop_one  (flush_wr && !abort_wr),
        .cnt_d     (cnt_d),
        .cnt_q     (cnt_q)
    );

    txep_retry #(.LIMIT(RETRY_LIMIT)) u_retry (
        .clk     (clk),
        .rst_n   (rst_n),
        .fail    (fail_ev),
        .clr     (sent_ev || flush_wr),
        .give_up (give_up)
    );

    txep_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (sent_ev),
        .clr   (tgl_clr_wr),
        .tgl_q (data_toggle)
    );

    always_comb begin
        fl_d = fl_q;
        // Events first.
        if (sent_ev || give_up) fl_d.rdy = 1'b0;
        if (give_up)            fl_d.err = 1'b1;
        // Then the register write.
        if (flush_wr)           fl_d.rdy = 1'b0;
        else if (commit_wr)     fl_d.rdy = (cnt_d == cap);
        if (err_clr_wr)         fl_d.err = 1'b0;
        fl_d.irq = sent_ev || give_up || flush_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    always_comb begin
        reg_rdata          = '0;
        reg_rdata[RDY_BIT] = fl_q.rdy;
        reg_rdata[FNE_BIT] = has_pkt;
        reg_rdata[ERR_BIT] = fl_q.err;
    end
    assign irq = fl_q.irq;

    // R12
    flush_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_wdata[FLS_BIT]) |=> irq);

    // R3
    rdy_has_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_q.rdy |-> cnt_q != '0);

    // R8
    give_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (give_up && !err_clr_wr && !commit_wr) |=> fl_q.err && cnt_q == '0);

    // R9
    iso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iso_mode && phy_nohs && !phy_sent && !reg_wr)
        |=> reg_rdata == $past(reg_rdata));
endmodule

// File: tb/usb_tx_ep_ctrl_test.sv
`timescale 1ns/1ps
module usb_tx_ep_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dbl_buf = 1'b0, iso_mode = 1'b0;
    logic       reg_wr = 1'b0, phy_sent = 1'b0, phy_nohs = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       data_toggle, irq;

    int n_chk = 0, n_bad = 0;
    int m_cnt, m_retry;
    bit m_rdy, m_err, m_tgl, m_irq;

    always #2.5 clk = ~clk;

    usb_tx_ep_ctrl uut (
        .clk(clk), .rst_n(rst_n), .dbl_buf(dbl_buf), .iso_mode(iso_mode),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .phy_sent(phy_sent), .phy_nohs(phy_nohs),
        .data_toggle(data_toggle), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte();
        return {5'b0, m_err, (m_cnt != 0), m_rdy};
    endfunction

    // Reference model built from the requirement list.
    task automatic model(input bit w, input logic [7:0] d, input bit s, input bit n);
        int cap = dbl_buf ? 2 : 1;
        m_irq = 0;
        if (s && m_cnt > 0) begin
            m_cnt--; m_rdy = 0; m_tgl = !m_tgl; m_retry = 0; m_irq = 1;
        end else if (n && m_cnt > 0 && !iso_mode) begin
            if (m_retry == 2) begin
                m_err = 1; m_cnt = 0; m_rdy = 0; m_retry = 0; m_irq = 1;
            end else m_retry++;
        end
        if (w) begin
            if (d[3]) begin
                m_irq = 1; m_retry = 0; m_rdy = 0;
                if (!d[0] && m_cnt > 0) m_cnt--;
            end else if (d[0]) begin
                if (m_cnt < cap) m_cnt++;
                m_rdy = (m_cnt == cap);
            end
            if (!d[2]) m_err = 0;
            if (d[6])  m_tgl = 0;
        end
    endtask

    task automatic step(input string tag, input bit w, input logic [7:0] d,
                        input bit s, input bit n);
        reg_wr = w; reg_wdata = d; phy_sent = s; phy_nohs = n;
        model(w, d, s, n);
        @(negedge clk);
        chk(tag, "rdata", reg_rdata, exp_byte());
        chk(tag, "toggle", data_toggle, m_tgl);
        chk(tag, "irq", irq, m_irq);
        reg_wr = 0; reg_wdata = 8'h00; phy_sent = 0; phy_nohs = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        m_cnt = 0; m_retry = 0; m_rdy = 0; m_err = 0; m_tgl = 0; m_irq = 0;
        chk("R1", "rdata", reg_rdata, 0);
        chk("R1", "toggle", data_toggle, 0);
        chk("R1", "irq", irq, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();
        // Single buffer
        step("R3", 1, 8'h05, 0, 0);   // commit
        step("R3", 1, 8'h05, 0, 0);   // full: ignored
        step("R5", 0, 8'h00, 1, 0);   // sent
        step("R12", 0, 8'h00, 0, 0);  // irq drops
        step("R5", 0, 8'h00, 1, 0);   // sent on empty
        step("R2", 1, 8'h02, 0, 0);   // bit 1 write ignored
        step("R6", 1, 8'h05, 0, 0);
        step("R6", 1, 8'h0C, 0, 0);   // flush one
        step("R6", 1, 8'h0C, 0, 0);   // flush at empty
        step("R7", 1, 8'h05, 0, 0);
        step("R7", 1, 8'h0D, 0, 0);   // flush+ready: count held
        step("R6", 1, 8'h0C, 0, 0);
        // Retry error
        step("R8", 1, 8'h05, 0, 0);
        step("R8", 0, 8'h00, 0, 1);
        step("R8", 0, 8'h00, 0, 1);
        step("R8", 0, 8'h00, 0, 1);   // third failure
        step("R10", 1, 8'h04, 0, 0);  // bit 2 set keeps error
        step("R10", 1, 8'h00, 0, 0);  // bit 2 clear clears error
        // Restart after sent
        step("R8", 1, 8'h05, 0, 0);
        step("R8", 0, 8'h00, 0, 1);
        step("R8", 0, 8'h00, 0, 1);
        step("R8", 0, 8'h00, 1, 0);
        step("R8", 1, 8'h05, 0, 0);
        step("R8", 0, 8'h00, 0, 1);
        step("R8", 0, 8'h00, 0, 1);   // no error yet
        step("R13", 0, 8'h00, 1, 1);  // sent wins over nohs
        // Isochronous
        iso_mode = 1;
        step("R9", 1, 8'h05, 0, 0);
        for (int i = 0; i < 4; i++) step("R9", 0, 8'h00, 0, 1);
        iso_mode = 0;
        step("R11", 1, 8'h44, 1, 0);  // clear beats flip
        step("R13", 1, 8'h05, 0, 0);
        step("R13", 0, 8'h00, 0, 1);
        step("R13", 0, 8'h00, 0, 1);
        step("R13", 1, 8'h00, 0, 1);  // error set, write clears it
        // Double buffer
        dbl_buf = 1;
        step("R4", 1, 8'h05, 0, 0);
        step("R4", 1, 8'h05, 0, 0);
        step("R4", 1, 8'h05, 0, 0);
        step("R4", 1, 8'h0C, 0, 0);
        step("R4", 1, 8'h0C, 0, 0);
        step("R4", 1, 8'h0C, 0, 0);
        // Random phases
        for (int ph = 0; ph < 6; ph++) begin
            dbl_buf = ph[0]; iso_mode = (ph == 4);
            do_reset();
            for (int k = 0; k < 3000; k++) begin
                bit w = ($urandom % 3) == 0;
                logic [7:0] d = 8'($urandom);
                bit s = ($urandom % 5) == 0;
                bit n = ($urandom % 3) == 0;
                if (($urandom % 2) == 0) d[3] = 0;
                step("R13", w, d, s, n);
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule